// File: doc/BRIEF.md
# External Bus Strobe Controller

This block runs one external bus cycle at a time. It drives the active-low read strobe, the write strobe (or low-byte write strobe) and the high-byte write strobe, and it decides in which clock the cycle ends. A CPU-side request port hands over each cycle with its full per-window setup:
- the address,
- the direction,
- the two byte enables,
- a programmed waitstate count,
- whether the external READY input may end the cycle,
- whether READY is taken directly or through a synchronizer,
- whether writes use one combined strobe or separate low and high byte strobes.

A single-clock `done` pulse marks the last strobe cycle.

The request port is a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and every request field steady until that edge. `req_ready` is low in four situations: while a cycle is running, while the bus hold request is high, while hold is granted, and during the clock that carries `done`. Addresses inside a configurable on-chip peripheral window are timed exactly like external cycles. For those addresses, a visibility control decides whether the strobes actually move.

Bus hold is a plain request/acknowledge pair. Hold is granted only between cycles, and all strobes rest high while it is granted.

Top module: `ebus_strobe_ctrl`

## Requirements
- R1: `rd_n`, `wr_n` and `wrh_n` are high whenever `rst_n` is low and whenever `hold_ack` is high.
- R2: A request is taken on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is high only when no cycle is running, `hold_req` is low and `hold_ack` is low.
- R3: A read asserts `rd_n` low from the clock after acceptance through the clock carrying `done`, inclusive. Neither write strobe moves during a read.
- R4: A write in combined mode (`req_split`=0) drives `wr_n` low for the whole cycle, whatever `req_be` holds. `wrh_n` stays high.
- R5: A write in split mode (`req_split`=1) drives `wr_n` low only if `req_be[0]` (low byte) is 1, and `wrh_n` low only if `req_be[1]` (high byte) is 1.
- R6: With `req_rdy_en`=0, the cycle lasts exactly 1+W strobe clocks, where W is `req_wait` (0 to 15). `done` is high in the last of them.
- R7: With `req_rdy_en`=1, READY is ignored in the first W strobe clocks. From strobe clock W+1 onward, the cycle ends in the first clock in which sampled READY is 1.
- R8: With `req_rdy_async`=0, sampled READY is the current `ready_in`. With `req_rdy_async`=1, it is the value `ready_in` had at the rising edge two edges before the current clock. The synchronizer flops reset to 0.
- R9: An address with `(req_addr & INT_MASK) == INT_BASE` is an on-chip peripheral access. For such an access, all strobes stay high unless `cfg_visible` was 1 at acceptance. Its timing is the same either way.
- R10: `done` is high for exactly one clock. All strobes are high in the next clock, and `req_ready` can be high in that next clock.
- R11: `hold_ack` rises on the edge after `hold_req` is seen high while no cycle is running, or on the edge that ends a cycle. `hold_ack` falls on the edge after `hold_req` is seen low. A request pending while hold is requested or granted waits.
- R12: `rd_n` and the write strobes are never low in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this clock |
| req_addr | input | AW (16) | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables; bit 0 is the low byte, bit 1 is the high byte |
| req_wait | input | WAIT_W (4) | Programmed waitstates |
| req_rdy_en | input | 1 | READY may end this cycle |
| req_rdy_async | input | 1 | READY passes through the synchronizer |
| req_split | input | 1 | Separate low and high byte write strobes |
| cfg_visible | input | 1 | Strobes move on peripheral-window accesses |
| hold_req | input | 1 | Bus hold request |
| hold_ack | output | 1 | Bus hold granted |
| ready_in | input | 1 | External READY, high = end cycle |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Combined write or low-byte write strobe, active low |
| wrh_n | output | 1 | High-byte write strobe, active low |
| done | output | 1 | Last strobe clock of the cycle |

## Verification
Two situations put two functions into the same clock. The first is a hold request that arrives while a cycle is still running. The bench raises `hold_req` in mid-cycle, and in random cases on the ending clock itself. The model must then show `hold_ack` rising on exactly the edge that drops the strobes, with the next request held back until hold is released. The second is READY arriving during the waitstates. The bench raises `ready_in` at the first strobe clock for windows with waitstates, in both the direct and the synchronized modes. The cycle-by-cycle model must see `done` only once the waitstates have run out, with the two-edge lag applied in synchronized mode.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  localparam int BE_W = 2;

  typedef struct packed {
    logic            write;
    logic [BE_W-1:0] be;
    logic            split;
    logic            show;
  } cyc_t;
endpackage

// File: rtl/ebs_ready_sync.sv
module ebs_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ready_in,
  output logic ready_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], ready_in};
  end

  assign ready_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ebs_cycle_timer.sv
module ebs_cycle_timer #(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_in,
  input  logic              rdy_en_in,
  input  logic              rdy_async_in,
  input  logic              ready_in,
  input  logic              ready_sync,
  output logic              busy,
  output logic              done
);
  logic              busy_q, en_q, async_q;
  logic [WAIT_W-1:0] cnt_q, lim_q;
  logic              reached, rdy_seen;

  assign reached  = (cnt_q == lim_q);
  assign rdy_seen = async_q ? ready_sync : ready_in;
  assign done     = busy_q && reached && (!en_q || rdy_seen);
  assign busy     = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      lim_q   <= '0;
      en_q    <= 1'b0;
      async_q <= 1'b0;
    end else if (start) begin
      busy_q  <= 1'b1;
      cnt_q   <= '0;
      lim_q   <= wait_in;
      en_q    <= rdy_en_in;
      async_q <= rdy_async_in;
    end else if (done) begin
      busy_q  <= 1'b0;
    end else if (busy_q && !reached) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // R7: with waitstates programmed, the first strobe clock never ends the cycle
  p_wait_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done || lim_q == '0));

  // R6: a cycle is over on the edge after done
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/ebs_strobe_gen.sv
module ebs_strobe_gen (
  input  logic           busy,
  input  ebs_pkg::cyc_t  cur,
  output logic           rd_n,
  output logic           wr_n,
  output logic           wrh_n
);
  logic                      act_w;
  logic [ebs_pkg::BE_W-1:0]  lane_on;

  assign act_w = busy && cur.write && cur.show;

  for (genvar i = 0; i < ebs_pkg::BE_W; i++) begin : g_lane
    if (i == 0) begin : g_low
      assign lane_on[i] = act_w && (!cur.split || cur.be[i]);
    end else begin : g_high
      assign lane_on[i] = act_w && cur.split && cur.be[i];
    end
  end

  assign rd_n  = !(busy && !cur.write && cur.show);
  assign wr_n  = !lane_on[0];
  assign wrh_n = !lane_on[1];
endmodule

// File: rtl/ebus_strobe_ctrl.sv
module ebus_strobe_ctrl #(
  parameter int              AW          = 16,
  parameter int              WAIT_W      = 4,
  parameter int              SYNC_STAGES = 2,
  parameter logic [AW-1:0]   INT_MASK    = 16'hF000,
  parameter logic [AW-1:0]   INT_BASE    = 16'hE000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [WAIT_W-1:0] req_wait,
  input  logic              req_rdy_en,
  input  logic              req_rdy_async,
  input  logic              req_split,
  input  logic              cfg_visible,
  input  logic              hold_req,
  output logic              hold_ack,
  input  logic              ready_in,
  output logic              rd_n,
  output logic              wr_n,
  output logic              wrh_n,
  output logic              done
);
  import ebs_pkg::*;

  logic  hold_ack_q, busy, done_w, accept, ready_sync, is_internal;
  cyc_t  cur_q;

  assign is_internal = ((req_addr & INT_MASK) == INT_BASE);
  assign req_ready   = !busy && !hold_req && !hold_ack_q;
  assign accept      = req_valid && req_ready;
  assign hold_ack    = hold_ack_q;
  assign done        = done_w;

  ebs_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .ready_in(ready_in), .ready_sync(ready_sync)
  );

  ebs_cycle_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .wait_in(req_wait),
    .rdy_en_in(req_rdy_en), .rdy_async_in(req_rdy_async),
    .ready_in(ready_in), .ready_sync(ready_sync),
    .busy(busy), .done(done_w)
  );

  ebs_strobe_gen u_strobe (
    .busy(busy), .cur(cur_q), .rd_n(rd_n), .wr_n(wr_n), .wrh_n(wrh_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q      <= '0;
      hold_ack_q <= 1'b0;
    end else begin
      hold_ack_q <= hold_req && (!busy || done_w);
      if (accept) begin
        cur_q.write <= req_write;
        cur_q.be    <= req_be;
        cur_q.split <= req_split;
        cur_q.show  <= !is_internal || cfg_visible;
      end
    end
  end

  // R1: strobes idle in reset
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (rd_n && wr_n && wrh_n)
        else $error("strobe active during reset");
    end
  end

  // R1: strobes idle while hold is granted
  p_hold_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> (rd_n && wr_n && wrh_n));

  // R11: nothing is taken while hold is requested or granted
  p_no_accept_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req || hold_ack) |-> !req_ready);

  // R10: done lasts one clock
  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: strobes released after done
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (rd_n && wr_n && wrh_n));

  // R12: read and write strobes exclusive
  p_rd_wr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (wr_n && wrh_n));

  // R3: a strobe can only start on the edge after a request was taken
  p_strobe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n) || $fell(wrh_n)) |-> $past(accept));
endmodule

// File: tb/ebus_strobe_ctrl_tb.sv
module ebus_strobe_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_rdy_en = 1'b0;
  logic req_rdy_async = 1'b0, req_split = 1'b0, cfg_visible = 1'b0;
  logic hold_req = 1'b0, ready_in = 1'b0;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_be = '0;
  logic [3:0]  req_wait = '0;
  logic req_ready, hold_ack, rd_n, wr_n, wrh_n, done;

  int n_total = 0;
  int n_bad   = 0;

  // reference model state
  bit m_busy = 0, m_en = 0, m_async = 0, m_write = 0, m_split = 0, m_show = 0, m_hack = 0;
  bit [1:0] m_be = 0;
  int m_k = 0, m_w = 0;
  bit rq[$] = '{1'b0, 1'b0};

  always #5 clk = ~clk;

  ebus_strobe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_be(req_be),
    .req_wait(req_wait), .req_rdy_en(req_rdy_en), .req_rdy_async(req_rdy_async),
    .req_split(req_split), .cfg_visible(cfg_visible), .hold_req(hold_req),
    .hold_ack(hold_ack), .ready_in(ready_in), .rd_n(rd_n), .wr_n(wr_n),
    .wrh_n(wrh_n), .done(done)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_total, n_bad);
  endtask

  task automatic cmp(input logic act, input bit exp, input string what);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %b expected %0b", what, $time, act, exp);
    end
  endtask

  function automatic bit in_window(input logic [15:0] a);
    return (a & 16'hF000) == 16'hE000;
  endfunction

  // one clock: compare just before the edge, then advance the model
  task automatic tick();
    bit r, e_rr, e_done, acc, hack_n;
    #3;
    r      = m_async ? rq[0] : ready_in;
    e_rr   = !m_busy && !hold_req && !m_hack;
    e_done = m_busy && (m_k >= m_w) && (!m_en || r);
    cmp(req_ready, e_rr, "R2/R10/R11 req_ready");
    cmp(hold_ack, m_hack, "R11 hold_ack");
    cmp(done, e_done, "R6/R7/R8 done");
    cmp(rd_n, !(m_busy && !m_write && m_show), "R1/R3/R9/R12 rd_n");
    cmp(wr_n, !(m_busy && m_write && m_show && (!m_split || m_be[0])), "R1/R4/R5/R9 wr_n");
    cmp(wrh_n, !(m_busy && m_write && m_show && m_split && m_be[1]), "R1/R5 wrh_n");
    acc    = req_valid && e_rr;
    hack_n = hold_req && (!m_busy || e_done);
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_hack = 0; m_k = 0;
      rq = '{1'b0, 1'b0};
    end else begin
      m_hack = hack_n;
      if (m_busy) begin
        if (e_done) m_busy = 0;
        else m_k++;
      end else if (acc) begin
        m_busy = 1; m_k = 0; m_w = int'(req_wait);
        m_en = req_rdy_en; m_async = req_rdy_async;
        m_write = req_write; m_be = req_be; m_split = req_split;
        m_show = !in_window(req_addr) || cfg_visible;
      end
      rq.push_back(ready_in);
      void'(rq.pop_front());
    end
    @(negedge clk);
  endtask

  task automatic run_cycle(input logic [15:0] a, input bit wr, input bit [1:0] be,
                           input int w, input bit en, input bit asy, input bit spl,
                           input int rdly, input int hold_at, input int hold_rel);
    int n;
    req_addr = a; req_write = wr; req_be = be; req_wait = 4'(w);
    req_rdy_en = en; req_rdy_async = asy; req_split = spl;
    req_valid = 1'b1; ready_in = 1'b0;
    if (hold_req) begin
      for (int i = 0; i < hold_rel; i++) tick();   // R11: request waits
      hold_req = 1'b0;
    end
    while (!m_busy) tick();
    req_valid = 1'b0;
    n = 0;
    while (m_busy) begin
      ready_in = (n >= rdly);
      if (n == hold_at) hold_req = 1'b1;
      tick();
      n++;
    end
    ready_in = 1'b0;
    tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) tick();            // R1 reset state
    rst_n = 1'b1;
    tick();
    // R3 / R6: reads with fixed length
    run_cycle(16'h1000, 0, 2'b11, 0, 0, 0, 0, 0, -1, 0);
    run_cycle(16'h1002, 0, 2'b11, 3, 0, 0, 0, 0, -1, 0);
    // R4: combined write for each byte pattern
    run_cycle(16'h2000, 1, 2'b01, 2, 0, 0, 0, 0, -1, 0);
    run_cycle(16'h2001, 1, 2'b10, 0, 0, 0, 0, 0, -1, 0);
    // R5: split write patterns
    run_cycle(16'h2002, 1, 2'b01, 1, 0, 0, 1, 0, -1, 0);
    run_cycle(16'h2003, 1, 2'b10, 1, 0, 0, 1, 0, -1, 0);
    run_cycle(16'h2004, 1, 2'b11, 0, 0, 0, 1, 0, -1, 0);
    // R7: READY high early is ignored during waitstates
    run_cycle(16'h3000, 0, 2'b11, 2, 1, 0, 0, 0, -1, 0);
    run_cycle(16'h3000, 1, 2'b11, 0, 1, 0, 0, 4, -1, 0);
    // R8: synchronized READY lag
    run_cycle(16'h3100, 0, 2'b11, 1, 1, 1, 0, 2, -1, 0);
    run_cycle(16'h3100, 1, 2'b01, 0, 1, 1, 1, 0, -1, 0);
    // R9: peripheral window hidden, then visible
    cfg_visible = 1'b0;
    run_cycle(16'hE010, 0, 2'b11, 1, 0, 0, 0, 0, -1, 0);
    run_cycle(16'hE020, 1, 2'b11, 0, 0, 0, 1, 0, -1, 0);
    cfg_visible = 1'b1;
    run_cycle(16'hE030, 1, 2'b11, 1, 0, 0, 1, 0, -1, 0);
    // R11: hold raised mid-cycle, next request deferred
    run_cycle(16'h4000, 0, 2'b11, 3, 0, 0, 0, 0, 1, 0);
    run_cycle(16'h4002, 1, 2'b11, 0, 0, 0, 0, 0, -1, 3);
    // R11: hold while idle
    hold_req = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    hold_req = 1'b0;
    for (int i = 0; i < 2; i++) tick();
    // mixed random cycles, hold sometimes raised on the ending clock
    for (int c = 0; c < 60; c++) begin
      int w, ha;
      w  = int'($urandom_range(0, 15));
      ha = ($urandom_range(0, 3) == 0) ? w : -1;
      cfg_visible = 1'($urandom_range(0, 1));
      run_cycle(16'($urandom_range(0, 65535)), 1'($urandom_range(0, 1)),
                2'($urandom_range(0, 3)), w, 1'($urandom_range(0, 1)),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 20)), ha, int'($urandom_range(1, 3)));
    end
    summary();
    $finish;
  end
endmodule